// File: doc/BRIEF.md
# Line Transmit Input Mode Controller

This block sits on the digital transmit side of one telecom line interface channel. A free-running reference clock oversamples four asynchronous pins: the transmit clock, the master clock, the positive (or data) input and the negative (or select) input. The block works out the operating mode from how these pins behave over time. It looks at how long the transmit clock is held at one level, whether the master clock is running, and how long the select input stays high. It then drives a positive-mark enable, a negative-mark enable and a driver-enable for the analog line stage that follows.

There are five operating conditions. In bipolar NRZ the two data pins are translated directly. In unipolar NRZ a single data stream is coded with alternating mark polarity. In return-to-zero pass-through the pulse width follows the input high time. In all-ones generation the marks are timed by the master clock. In power-down the drivers are disabled. Every pin passes through a two-flop synchronizer before any decision is made. In the NRZ modes each mark lasts one transmit-clock bit period, from one falling edge to the next.

Top module: `tx_mode_ctrl`

## Requirements
- R1: After reset, `drv_en_o`, `mark_p_o` and `mark_n_o` are all 0. They stay 0 until the first rising edge of the transmit clock. Once that edge arrives the block runs in bipolar NRZ with `drv_en_o` = 1.
- R2: In bipolar NRZ, each transmit-clock falling edge samples the two data pins and the result is held until the next falling edge. The translation is: pos=1, neg=0 gives `mark_p_o`=1. pos=0, neg=1 gives `mark_n_o`=1. Both 0 or both 1 give a space, with both marks 0.
- R3: With the master clock present, a falling edge that samples neg=1 after at least UNI_RUN consecutive earlier samples of neg=1 is handled as unipolar (so the (UNI_RUN+1)-th sample onward). Any falling edge that samples neg=0 returns the block to bipolar translation at that same edge.
- R4: In unipolar mode a sampled pos=1 gives a mark and a sampled pos=0 gives a space. Mark polarity alternates, and the first mark after reset is positive.
- R5: Unipolar mode is never selected while the master clock is absent. The master clock counts as absent when it has had no rising edge within the last MCLK_WIN reference cycles.
- R6: With the master clock present, once the transmit clock has been high for AOS_EDGES master-clock rising edges, the block generates all-ones. It produces one mark per master-clock rising edge, alternating in polarity, with exactly one mark enable high at a time. The block returns to NRZ on the next transmit-clock falling edge.
- R7: With the master clock absent, once the transmit clock has been high for RZ_HOLD reference cycles, the marks follow the data pins three reference cycles later. `mark_p_o` = pos AND NOT neg and `mark_n_o` = neg AND NOT pos, so the mark width equals the input high time. A transmit-clock falling edge returns the block to NRZ.
- R8: If the transmit clock stays low for TCLK_WIN reference cycles, `drv_en_o` and both marks go to 0. The next transmit-clock rising edge restores `drv_en_o`.
- R9: `mark_p_o` and `mark_n_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tclk_i | input | 1 | Transmit clock pin (asynchronous) |
| mclk_i | input | 1 | Master clock pin (asynchronous) |
| pos_i | input | 1 | Positive pulse / unipolar data pin (asynchronous) |
| neg_i | input | 1 | Negative pulse / unipolar select pin (asynchronous) |
| mark_p_o | output | 1 | Positive-mark enable to the line stage |
| mark_n_o | output | 1 | Negative-mark enable to the line stage |
| drv_en_o | output | 1 | Line-driver enable; 0 means high impedance |

## Verification
The bench builds the block with MCLK_WIN=8, TCLK_WIN=16 and RZ_HOLD=40, and keeps AOS_EDGES and UNI_RUN at 16. These short windows mean the master-clock absence, power-down and return-to-zero entries each take only tens of reference cycles, so every mode is reached in one run. With a master clock of three reference cycles, the all-ones mark count over a fixed window is exact. The full 16-sample select run is stepped bit by bit, so the unipolar switch is seen exactly at the seventeenth sample.

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl #(
  parameter int MCLK_WIN  = 64,
  parameter int TCLK_WIN  = 64,
  parameter int RZ_HOLD   = 1200,
  parameter int AOS_EDGES = 16,
  parameter int UNI_RUN   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_i,
  input  logic mclk_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic mark_p_o,
  output logic mark_n_o,
  output logic drv_en_o
);

  localparam int MW = $clog2(MCLK_WIN + 1);
  localparam int LW = $clog2(TCLK_WIN + 1);
  localparam int HW = $clog2(RZ_HOLD + 1);
  localparam int AW = $clog2(AOS_EDGES + 1);
  localparam int UW = $clog2(UNI_RUN + 1);
  localparam logic [MW-1:0] M_MAX = MW'(MCLK_WIN);
  localparam logic [LW-1:0] L_MAX = LW'(TCLK_WIN);
  localparam logic [HW-1:0] H_MAX = HW'(RZ_HOLD);
  localparam logic [AW-1:0] A_MAX = AW'(AOS_EDGES);
  localparam logic [UW-1:0] U_MAX = UW'(UNI_RUN);

  typedef enum logic [1:0] {ST_OFF, ST_NRZ, ST_RZ, ST_AOS} mode_t;

  logic [2:0]    tclk_q, mclk_q;
  logic [1:0]    pos_q, neg_q;
  logic [MW-1:0] mclk_age;
  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;
  logic [AW-1:0] aos_cnt;
  logic [UW-1:0] neg_run;
  logic          ami, mp, mn;
  logic          ami_nx, mp_nx, mn_nx;
  mode_t         state, state_nx;

  wire tclk_s    = tclk_q[1];
  wire pos_s     = pos_q[1];
  wire neg_s     = neg_q[1];
  wire tclk_fall = tclk_q[2] & ~tclk_q[1];
  wire tclk_rise = ~tclk_q[2] & tclk_q[1];
  wire mclk_rise = ~mclk_q[2] & mclk_q[1];
  wire mclk_pres = (mclk_age != M_MAX);
  wire idle      = (lo_cnt == L_MAX) & ~tclk_s;
  wire uni_now   = neg_s & mclk_pres & (neg_run == U_MAX);

  always_comb begin
    state_nx = state;
    case (state)
      ST_OFF: if (tclk_rise) state_nx = ST_NRZ;
      ST_NRZ: begin
        if (idle) state_nx = ST_OFF;
        else if (tclk_s && mclk_pres && aos_cnt == A_MAX) state_nx = ST_AOS;
        else if (tclk_s && !mclk_pres && hi_cnt == H_MAX) state_nx = ST_RZ;
      end
      default: begin
        if (idle) state_nx = ST_OFF;
        else if (tclk_fall) state_nx = ST_NRZ;
      end
    endcase
  end

  always_comb begin
    mp_nx  = mp;
    mn_nx  = mn;
    ami_nx = ami;
    if (state_nx == ST_OFF) begin
      mp_nx = 1'b0;
      mn_nx = 1'b0;
    end else begin
      case (state)
        ST_NRZ: if (tclk_fall) begin
          if (uni_now) begin
            mp_nx  = pos_s & ~ami;
            mn_nx  = pos_s & ami;
            ami_nx = ami ^ pos_s;
          end else begin
            mp_nx = pos_s & ~neg_s;
            mn_nx = neg_s & ~pos_s;
          end
        end
        ST_RZ: begin
          mp_nx = pos_s & ~neg_s;
          mn_nx = neg_s & ~pos_s;
        end
        ST_AOS: if (mclk_rise) begin
          mp_nx  = ~ami;
          mn_nx  = ami;
          ami_nx = ~ami;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tclk_q   <= '0;
      mclk_q   <= '0;
      pos_q    <= '0;
      neg_q    <= '0;
      mclk_age <= M_MAX;
      lo_cnt   <= '0;
      hi_cnt   <= '0;
      aos_cnt  <= '0;
      neg_run  <= '0;
      ami      <= 1'b0;
      mp       <= 1'b0;
      mn       <= 1'b0;
      state    <= ST_OFF;
    end else begin
      tclk_q   <= {tclk_q[1:0], tclk_i};
      mclk_q   <= {mclk_q[1:0], mclk_i};
      pos_q    <= {pos_q[0], pos_i};
      neg_q    <= {neg_q[0], neg_i};
      mclk_age <= mclk_rise ? '0 : (mclk_pres ? mclk_age + 1'b1 : mclk_age);
      lo_cnt   <= tclk_s ? '0 : (lo_cnt == L_MAX ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt   <= !tclk_s ? '0 : (hi_cnt == H_MAX ? hi_cnt : hi_cnt + 1'b1);
      aos_cnt  <= !tclk_s ? '0 :
                  ((mclk_rise && aos_cnt != A_MAX) ? aos_cnt + 1'b1 : aos_cnt);
      if (tclk_fall)
        neg_run <= !neg_s ? '0 : (neg_run == U_MAX ? neg_run : neg_run + 1'b1);
      ami      <= ami_nx;
      mp       <= mp_nx;
      mn       <= mn_nx;
      state    <= state_nx;
    end
  end

  assign mark_p_o = mp;
  assign mark_n_o = mn;
  assign drv_en_o = (state != ST_OFF);

  a_r9_marks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_p_o && mark_n_o));

  a_r8_idle_disables: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !drv_en_o && !mark_p_o && !mark_n_o);

  a_r6_aos_exit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AOS && tclk_fall) |=> (state == ST_NRZ));

  a_r7_rz_entry_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RZ && $past(state) != ST_RZ) |-> ($past(hi_cnt) == H_MAX && !$past(mclk_pres)));

endmodule

// File: tb/tx_mode_ctrl_test.sv
module tx_mode_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tclk = 1'b0, mclk = 1'b0, pos = 1'b0, neg = 1'b0;
  logic mclk_on = 1'b0;
  logic mark_p, mark_n, drv_en;
  int   nchk = 0, nerr = 0;
  logic ami_b = 1'b0;

  tx_mode_ctrl #(.MCLK_WIN(8), .TCLK_WIN(16), .RZ_HOLD(40), .AOS_EDGES(16), .UNI_RUN(16)) uut (
    .clk(clk), .rst_n(rst_n), .tclk_i(tclk), .mclk_i(mclk), .pos_i(pos), .neg_i(neg),
    .mark_p_o(mark_p), .mark_n_o(mark_n), .drv_en_o(drv_en));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #2;
    forever begin
      #15;
      mclk <= mclk_on ? ~mclk : 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int outs();
    return {drv_en, mark_p, mark_n};
  endfunction

  function automatic int bip(input logic p, input logic n);
    return {1'b1, p & ~n, n & ~p};
  endfunction

  function automatic int uni(input logic p);
    int r;
    if (p) begin
      r = {1'b1, ~ami_b, ami_b};
      ami_b = ~ami_b;
    end else r = 3'b100;
    return r;
  endfunction

  task automatic send(input logic p, input logic n);
    @(negedge clk);
    pos = p; neg = n; tclk = 1'b1;
    repeat (4) @(negedge clk);
    tclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    int cnt, chg, bad;
    logic pp, pn;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R1 reset outputs", outs(), 0);
    mclk_on = 1'b1;
    wait_cyc(20);
    chk("R1 disabled without tclk", outs(), 0);
    send(1'b0, 1'b0);
    chk("R1 enabled after tclk", outs(), 3'b100);

    // R2 bipolar sweep, twice
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 4; v++) begin
        send(v[1], v[0]);
        chk("R2 bipolar", outs(), bip(v[1], v[0]));
      end

    // R3 / R4 unipolar entry, AMI, exit
    send(1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      send(1'b0, 1'b1);
      chk("R3 select run still bipolar", outs(), bip(1'b0, 1'b1));
    end
    send(1'b1, 1'b1);
    chk("R3 unipolar at 17th sample", outs(), uni(1'b1));
    for (int i = 0; i < 4; i++) begin
      logic d;
      d = (i != 1);
      send(d, 1'b1);
      chk("R4 unipolar AMI", outs(), uni(d));
    end
    send(1'b1, 1'b0);
    chk("R3 back to bipolar", outs(), bip(1'b1, 1'b0));

    // R5 no unipolar without master clock
    mclk_on = 1'b0;
    wait_cyc(12);
    for (int i = 0; i < 20; i++) begin
      send(1'b1, 1'b1);
      chk("R5 bipolar space without mclk", outs(), bip(1'b1, 1'b1));
    end
    mclk_on = 1'b1;
    wait_cyc(12);
    send(1'b1, 1'b1);
    chk("R5 unipolar once mclk returns", outs(), uni(1'b1));

    // R6 all-ones generation
    @(negedge clk);
    pos = 1'b0; neg = 1'b0; tclk = 1'b1;
    wait_cyc(90);
    pp = mark_p; pn = mark_n; chg = 0; bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if ((mark_p ^ mark_n) != 1'b1 || !drv_en) bad++;
      if (mark_p != pp) begin
        chg++;
        if (mark_p != pn) bad++;
      end
      pp = mark_p; pn = mark_n;
    end
    chk("R6 R9 one alternating mark", bad, 0);
    chk("R6 one mark per mclk edge", chg, 20);
    tclk = 1'b0;
    wait_cyc(4);
    send(1'b0, 1'b1);
    chk("R6 NRZ after tclk fall", outs(), bip(1'b0, 1'b1));

    // R7 return-to-zero pass-through
    mclk_on = 1'b0;
    @(negedge clk);
    pos = 1'b0; neg = 1'b0; tclk = 1'b1;
    wait_cyc(60);
    chk("R7 rz idle", outs(), 3'b100);
    pos = 1'b1; wait_cyc(4);
    chk("R7 rz positive", outs(), 3'b110);
    pos = 1'b0; neg = 1'b1; wait_cyc(4);
    chk("R7 rz negative", outs(), 3'b101);
    pos = 1'b1; wait_cyc(4);
    chk("R7 rz both is space", outs(), 3'b100);
    pos = 1'b0; neg = 1'b0; wait_cyc(4);
    cnt = 0;
    pos = 1'b1;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      cnt += int'(mark_p);
      if (i == 6) pos = 1'b0;
    end
    chk("R7 rz pulse width", cnt, 6);
    tclk = 1'b0;
    wait_cyc(4);
    send(1'b1, 1'b0);
    chk("R7 NRZ after rz", outs(), bip(1'b1, 1'b0));

    // R8 power-down and recovery
    wait_cyc(30);
    chk("R8 idle disables", outs(), 0);
    send(1'b0, 1'b1);
    chk("R8 recovery", outs(), bip(1'b0, 1'b1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule